// File: doc/BRIEF.md
# Noise-Shaped PWM Audio DAC

This block converts a 15-bit audio sample into a one-bit pin stream for an external low-pass filter. A first-order error-feedback quantiser reduces each sample to a 5-bit duty value. That duty value then drives a pulse-width modulator whose frame is always 32 clocks long. The pulses therefore start at regular intervals and only their width changes. The 10 bits that the duty value cannot carry are held as a residue and added into the next frame's sum. Over many frames this residue restores the full input resolution.

The quantiser runs once per PWM frame. A settable frame schedule can discard the residue at fixed intervals. This stops a near-zero input from building up slow, regularly spaced pulses that would be heard as idle tones. The sample is read only at frame boundaries, so the host may change it at any time.

Top module: `hybrid_dac`

## Requirements
- R1: While `rst_n` is low, `pwm_out` is 0. Frame 0 after reset release has duty 0, so `pwm_out` stays 0 for its 32 clocks.
- R2: Clocks are counted from the first rising edge with `rst_n` high, starting at 1. Frame k covers clocks 32k+1 to 32k+32. In a frame with duty D (0 to 31), `pwm_out` is 1 on the first D clocks and 0 on the rest. The last clock of every frame is therefore always 0.
- R3: At the end of each frame the unsigned sum S = sample + residue (residue 10 bits, 0 after reset) is formed. The next frame's duty is S[14:10] and the new residue is S[9:0].
- R4: `sample_in` is read only on the last clock of a frame. A change made partway through a frame alters neither that frame nor the one after it unless it is still present at the frame's end.
- R5: Hold `sample_in` at a constant X ≤ 31744 with clearing off. Counting from reset, the total number of high clocks over frames 1 to 1024 then equals X.
- R6: If S exceeds 32767, the duty is 31 and the residue becomes 1023.
- R7: With `clr_en` = 1 and `clr_interval` = N > 0, every N-th frame update after reset writes 0 to the residue. The first such update is the N-th. The duty produced by that update still comes from the full sum S.
- R8: With `clr_en` = 0, or with `clr_interval` = 0, the residue is never cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one PWM slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_in | input | 15 | Unsigned audio sample |
| clr_en | input | 1 | Enables the periodic residue clear |
| clr_interval | input | 8 | Frame updates between residue clears; 0 turns clearing off |
| pwm_out | output | 1 | Pulse-width modulated output pin |

## Verification
A duty update and a scheduled residue clear can fall on the same frame-end clock. The interval-2 case uses a sample of 700, so every clearing update is also the one that emits a one-slot pulse. It is judged by that frame showing exactly one high slot and the frame after it restarting from an empty residue. A sample change and a frame boundary also meet: the bench changes the sample ten slots into a frame and checks each later frame's pulse pattern against a frame-by-frame model.

// File: rtl/hdac_pkg.sv
// hdac_pkg: shared default widths for the noise-shaped PWM DAC.
// Assumes: all modules derive their local sizes from these defaults.
package hdac_pkg;
    parameter int unsigned DEF_SAMPLE_W = 15;
    parameter int unsigned DEF_DUTY_W   = 5;
    parameter int unsigned DEF_SCHED_W  = 8;
endpackage

// File: rtl/frame_timer.sv
// frame_timer: free-running slot counter; one frame is 2**DUTY_W clocks.
// Assumes: frame_end_o marks the last slot, on which the duty is renewed.
module frame_timer #(
    parameter int unsigned DUTY_W = hdac_pkg::DEF_DUTY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DUTY_W-1:0] slot_o,
    output logic              frame_end_o
);
    logic [DUTY_W-1:0] slot_q;

    // Advance the slot index, wrapping at the end of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_q + 1'b1;
    end

    assign slot_o      = slot_q;
    assign frame_end_o = &slot_q;

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> (slot_o == '0));
endmodule

// File: rtl/noise_shaper.sv
// noise_shaper: first-order error feedback from SAMPLE_W to DUTY_W bits,
// updated once per frame, with saturation and an optional periodic
// residue clear. Assumes frame_end_i is high for one clock per frame.
module noise_shaper #(
    parameter int unsigned SAMPLE_W = hdac_pkg::DEF_SAMPLE_W,
    parameter int unsigned DUTY_W   = hdac_pkg::DEF_DUTY_W,
    parameter int unsigned SCHED_W  = hdac_pkg::DEF_SCHED_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_end_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                clr_en_i,
    input  logic [SCHED_W-1:0]  clr_interval_i,
    output logic [DUTY_W-1:0]   duty_o
);
    localparam int unsigned RES_W = SAMPLE_W - DUTY_W;
    localparam int unsigned SUM_W = SAMPLE_W + 1;

    logic [RES_W-1:0]   residue_q;
    logic [DUTY_W-1:0]  duty_q;
    logic [SCHED_W-1:0] fcnt_q;
    logic [SUM_W-1:0]   sum;
    logic               ovf;
    logic [DUTY_W-1:0]  duty_nx;
    logic [RES_W-1:0]   res_nx;
    logic               sched_on;
    logic               clr_fire;

    // Form the sum and split it, saturating when it leaves the sample range.
    always_comb begin
        sum      = {1'b0, sample_i} + {{(SUM_W-RES_W){1'b0}}, residue_q};
        ovf      = sum[SUM_W-1];
        duty_nx  = ovf ? '1 : sum[SAMPLE_W-1:RES_W];
        res_nx   = ovf ? '1 : sum[RES_W-1:0];
        sched_on = clr_en_i && (clr_interval_i != '0);
        clr_fire = sched_on && (fcnt_q >= (clr_interval_i - 1'b1));
    end

    // Latch the duty and residue at the frame boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q    <= '0;
            residue_q <= '0;
        end else if (frame_end_i) begin
            duty_q    <= duty_nx;
            residue_q <= clr_fire ? '0 : res_nx;
        end
    end

    // Count frame updates toward the next scheduled residue clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !sched_on) fcnt_q <= '0;
        else if (frame_end_i)    fcnt_q <= clr_fire ? '0 : fcnt_q + 1'b1;
    end

    assign duty_o = duty_q;

    assert_duty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_end_i) |-> $stable(duty_q));
    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && ovf) |=> (duty_q == '1));
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && clr_fire) |=> (residue_q == '0));
    assert_sched_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sched_on |=> (fcnt_q == '0));
endmodule

// File: rtl/pwm_stage.sv
// pwm_stage: registered comparator; the pin is high while slot < duty.
// Assumes: duty changes only at the frame boundary, so no frame is split.
module pwm_stage #(
    parameter int unsigned DUTY_W = hdac_pkg::DEF_DUTY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] slot_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pwm_o
);
    logic pwm_q;

    // Register the compare result so the pin is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= (slot_i < duty_i);
    end

    assign pwm_o = pwm_q;

    assert_reset_low_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> !pwm_q);
    assert_last_slot_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_i == '0) |-> !pwm_q);
    assert_rise_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_q) |-> (slot_i == 1));
endmodule

// File: rtl/hybrid_dac.sv
// hybrid_dac: noise-shaped PWM audio DAC top. A frame timer paces a
// first-order quantiser that feeds a constant-period PWM pin.
// Assumes: an external analogue filter follows pwm_out.
module hybrid_dac #(
    parameter int unsigned SAMPLE_W = hdac_pkg::DEF_SAMPLE_W,
    parameter int unsigned DUTY_W   = hdac_pkg::DEF_DUTY_W,
    parameter int unsigned SCHED_W  = hdac_pkg::DEF_SCHED_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                clr_en,
    input  logic [SCHED_W-1:0]  clr_interval,
    output logic                pwm_out
);
    logic [DUTY_W-1:0] slot;
    logic              frame_end;
    logic [DUTY_W-1:0] duty;

    frame_timer #(.DUTY_W(DUTY_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .slot_o(slot), .frame_end_o(frame_end)
    );

    noise_shaper #(.SAMPLE_W(SAMPLE_W), .DUTY_W(DUTY_W), .SCHED_W(SCHED_W)) u_shaper (
        .clk(clk), .rst_n(rst_n), .frame_end_i(frame_end), .sample_i(sample_in),
        .clr_en_i(clr_en), .clr_interval_i(clr_interval), .duty_o(duty)
    );

    pwm_stage #(.DUTY_W(DUTY_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .slot_i(slot), .duty_i(duty), .pwm_o(pwm_out)
    );
endmodule

// File: tb/hybrid_dac_test.sv
// hybrid_dac_test: directed scenarios, each checking every frame's pulse
// pattern against a frame-level model built from the requirements.
module hybrid_dac_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] sample_in = '0;
    logic        clr_en = 1'b0;
    logic [7:0]  clr_interval = '0;
    logic        pwm_out;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hybrid_dac uut (
        .clk(clk), .rst_n(rst_n), .sample_in(sample_in),
        .clr_en(clr_en), .clr_interval(clr_interval), .pwm_out(pwm_out)
    );

    // End a hung run as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Reset with the given settings; R1: pin low throughout reset.
    task automatic do_reset(input int x, input bit en, input int iv);
        rst_n = 1'b0;
        sample_in = 15'(x);
        clr_en = en;
        clr_interval = 8'(iv);
        repeat (3) @(negedge clk);
        check("R1 pin low in reset", pwm_out, 0);
        rst_n = 1'b1;
    endtask

    // Run nframes; x2 is applied 10 slots into frame chg (R4).
    task automatic run_case(input string tag, input int nframes, input int x,
                            input int x2, input int chg, input bit en,
                            input int iv, input bit chk_total, input int exp_total);
        int acc = 0;
        int fc = 0;
        int d = 0;
        int total = 0;
        do_reset(x, en, iv);
        for (int f = 0; f < nframes; f++) begin
            logic [31:0] pat = '0;
            logic [31:0] exp_pat;
            for (int j = 0; j < 32; j++) begin
                @(negedge clk);
                pat[j] = pwm_out;
                total += int'(pwm_out);
                if (f == chg && j == 10) sample_in = 15'(x2);
            end
            exp_pat = (d == 0) ? 32'h0 : (32'hFFFF_FFFF >> (32 - d));
            checks++;
            if (pat !== exp_pat) begin
                errors++;
                $display("FAIL %s R2 R3 frame %0d: got %h expected %h", tag, f, pat, exp_pat);
            end
            begin
                int s = int'(sample_in) + acc;
                if (s > 32767) begin d = 31; acc = 1023; end
                else begin d = s >> 10; acc = s & 1023; end
                if (en && iv != 0) begin
                    if (fc >= iv - 1) begin acc = 0; fc = 0; end
                    else fc++;
                end
            end
        end
        if (chk_total) check({tag, " R5 total high"}, total, exp_total);
    endtask

    task automatic t_zero();     run_case("R1 zero input", 16, 0, 0, -1, 1'b0, 0, 1'b1, 0); endtask
    task automatic t_small();    run_case("R5 x=1000", 1025, 1000, 1000, -1, 1'b0, 0, 1'b1, 1000); endtask
    task automatic t_mid();      run_case("R3 x=12345", 1025, 12345, 12345, -1, 1'b0, 0, 1'b1, 12345); endtask
    task automatic t_top();      run_case("R2 x=31744", 40, 31744, 31744, -1, 1'b0, 0, 1'b1, 31 * 39); endtask
    task automatic t_sat();      run_case("R6 x=32767", 40, 32767, 32767, -1, 1'b0, 0, 1'b1, 31 * 39); endtask
    task automatic t_change();   run_case("R4 mid-frame change", 24, 20000, 3000, 5, 1'b0, 0, 1'b0, 0); endtask
    task automatic t_coincide(); run_case("R7 clear with pulse", 64, 700, 700, -1, 1'b1, 2, 1'b0, 0); endtask
    task automatic t_idle();     run_case("R7 idle suppressed", 64, 100, 100, -1, 1'b1, 4, 1'b1, 0); endtask
    task automatic t_iv_zero();  run_case("R8 interval zero", 1025, 5000, 5000, -1, 1'b1, 0, 1'b1, 5000); endtask
    task automatic t_en_off();   run_case("R8 enable low", 64, 100, 100, -1, 1'b0, 4, 1'b0, 0); endtask

    initial begin
        t_zero();
        t_small();
        t_mid();
        t_top();
        t_sat();
        t_change();
        t_coincide();
        t_idle();
        t_iv_zero();
        t_en_off();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule